// File: doc/BRIEF.md
# Internal Error Status Word with Read-to-Clear

This block gathers the processor's internal error events into one 16-bit status word. It also raises the request for the internal-error interrupt, which is the most urgent interrupt level. Four conditions are watched:
- an undefined operation code;
- a memory data transfer whose parity is wrong;
- a write aimed at a read-only location;
- a channel address failure, which comes either from a direct check or from a command reject caused by parity.

Each condition latches a bit of its own. A companion bit records that the failing event took place while auxiliary storage was being accessed.

The interrupt handler finds the cause by sensing the word. The current word is driven on the output every cycle. A sense strobe clears the stored word at the next clock edge. An error event that arrives in the same cycle as the sense is not lost: it lands in the freshly cleared word. Bits above the companion bit are always zero.

Top module: `int_err_status`

## Requirements
- R1: An invalid-opcode event sets bit 0 of the word (mask 0x0001) at the next clock edge.
- R2: While the transfer-valid input is high, the 16 data bits and the parity bit are counted together. An even count of ones, zero included, sets bit 1 (mask 0x0002). An odd count, or a low transfer-valid input, leaves bit 1 unchanged.
- R3: A write strobe with the protect flag high sets bit 2 (mask 0x0004). A write with the protect flag low has no effect on the word.
- R4: A channel address check event or a parity-caused command reject event sets bit 3 (mask 0x0008). Either event alone is enough.
- R5: Bit 4 (mask 0x0010) is set together with the causing bit when any R1 to R4 condition occurs while the auxiliary-access flag is high. The auxiliary flag with no cause has no effect.
- R6: Set bits stay set, and new causes add to them, until a sense.
- R7: A sense strobe with no error event clears the whole word to 0x0000 at the next clock edge.
- R8: An error event in the same cycle as a sense appears in the word after that edge. The bits present before the sense are cleared.
- R9: Bits 15 to 5 of the word always read as zero.
- R10: The interrupt request output is high exactly when any of bits 0 to 3 is set.
- R11: After reset the word is 0x0000 and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bad_opcode_i | input | 1 | Undefined operation code detected |
| xfer_valid_i | input | 1 | Memory data transfer present this cycle |
| xfer_data_i | input | 16 | Transferred memory word |
| xfer_par_i | input | 1 | Parity bit of the transferred word |
| wr_en_i | input | 1 | Memory write strobe |
| wr_protect_i | input | 1 | Target location is read-only |
| chan_check_i | input | 1 | Channel address check event |
| cmd_reject_i | input | 1 | Command reject caused by parity |
| aux_access_i | input | 1 | Current access is to auxiliary storage |
| sense_i | input | 1 | Sense strobe, clears the word at the next edge |
| word_o | output | 16 | Current status word |
| irq_o | output | 1 | Internal-error interrupt request |

## Verification
Every result is due exactly one clock edge after its stimulus. An error event, a sense and a combined event-plus-sense each show their effect on the word and the interrupt request right after the rising edge that sampled them. The interrupt request follows the stored bits with no further delay. The bench drives inputs on the falling edge and holds them for one cycle. It then releases them and checks the outputs on the next falling edge, so each check lands one edge after its stimulus. Reset release passes through a two-stage synchronizer, so the bench waits several cycles before driving any event.

// File: rtl/int_err_status_pkg.sv
package int_err_status_pkg;
  localparam int WORD_W   = 16;
  localparam int DATA_W   = 16;
  localparam int CAUSE_W  = 4;
  localparam int BIT_OPC  = 0;
  localparam int BIT_PAR  = 1;
  localparam int BIT_PROT = 2;
  localparam int BIT_CHAN = 3;
  localparam int BIT_AUX  = CAUSE_W;
  localparam int STATE_W  = CAUSE_W + 1;
  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [STATE_W-1:0] state_t;
endpackage

// File: rtl/int_err_status_rst_sync.sv
module int_err_status_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/int_err_status_parity.sv
module int_err_status_parity #(
  parameter int DATA_W = 16
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              err
);
  logic [DATA_W:0] run;

  assign run[0] = par;
  for (genvar i = 0; i < DATA_W; i++) begin : g_xor
    assign run[i+1] = run[i] ^ data[i];
  end

  // Odd parity is required: an even total count of ones is an error.
  assign err = valid & ~run[DATA_W];
endmodule

// File: rtl/int_err_status_detect.sv
module int_err_status_detect
  import int_err_status_pkg::*;
(
  input  logic              bad_opcode,
  input  logic              par_err,
  input  logic              wr_en,
  input  logic              wr_protect,
  input  logic              chan_check,
  input  logic              cmd_reject,
  input  logic              aux_access,
  output state_t            set_vec
);
  cause_t cause;

  always_comb begin
    cause           = '0;
    cause[BIT_OPC]  = bad_opcode;
    cause[BIT_PAR]  = par_err;
    cause[BIT_PROT] = wr_en & wr_protect;
    cause[BIT_CHAN] = chan_check | cmd_reject;
    set_vec         = {aux_access & (|cause), cause};
  end
endmodule

// File: rtl/int_err_status_reg.sv
module int_err_status_reg
  import int_err_status_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  state_t set_vec,
  input  logic   sense,
  output state_t state
);
  state_t state_q;
  state_t state_d;
  logic   en;

  always_comb begin
    en      = sense | (|set_vec);
    state_d = (sense ? '0 : state_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= '0;
    else if (en) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/int_err_status.sv
module int_err_status
  import int_err_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bad_opcode_i,
  input  logic              xfer_valid_i,
  input  logic [DATA_W-1:0] xfer_data_i,
  input  logic              xfer_par_i,
  input  logic              wr_en_i,
  input  logic              wr_protect_i,
  input  logic              chan_check_i,
  input  logic              cmd_reject_i,
  input  logic              aux_access_i,
  input  logic              sense_i,
  output logic [WORD_W-1:0] word_o,
  output logic              irq_o
);
  logic   rst_n_sync;
  logic   par_err;
  state_t set_vec;
  state_t state;

  int_err_status_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  int_err_status_parity #(.DATA_W(DATA_W)) u_par (
    .valid(xfer_valid_i), .data(xfer_data_i), .par(xfer_par_i), .err(par_err)
  );

  int_err_status_detect u_det (
    .bad_opcode(bad_opcode_i), .par_err(par_err), .wr_en(wr_en_i),
    .wr_protect(wr_protect_i), .chan_check(chan_check_i),
    .cmd_reject(cmd_reject_i), .aux_access(aux_access_i), .set_vec(set_vec)
  );

  int_err_status_reg u_reg (
    .clk(clk), .rst_n(rst_n_sync), .set_vec(set_vec), .sense(sense_i),
    .state(state)
  );

  assign word_o = {{(WORD_W-STATE_W){1'b0}}, state};
  assign irq_o  = |state[CAUSE_W-1:0];
endmodule

// File: rtl/int_err_status_chk.sv
module int_err_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bad_opcode_i,
  input logic        wr_en_i,
  input logic        wr_protect_i,
  input logic        chan_check_i,
  input logic        cmd_reject_i,
  input logic        sense_i,
  input logic [15:0] word_o,
  input logic        irq_o
);
  assert_opcode_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode_i |=> word_o[0]);

  assert_protect_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_protect_i) |=> word_o[2]);

  assert_chan_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_check_i || cmd_reject_i) |=> word_o[3]);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_i |=> ((word_o & $past(word_o)) == $past(word_o)));

  assert_sense_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && !bad_opcode_i && !wr_en_i && !chan_check_i && !cmd_reject_i
     && $past(rst_n)) |=> (word_o[3:0] == 4'h0 || word_o[1]));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_o[15:5] == 11'h0);

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (word_o[3:0] != 4'h0));

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (word_o[4:0] == 5'h0));
endmodule

bind int_err_status int_err_status_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .bad_opcode_i(bad_opcode_i),
  .wr_en_i(wr_en_i), .wr_protect_i(wr_protect_i),
  .chan_check_i(chan_check_i), .cmd_reject_i(cmd_reject_i),
  .sense_i(sense_i), .word_o(word_o), .irq_o(irq_o)
);

// File: tb/int_err_status_tb_top.sv
module int_err_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {op, xv, data[15:0], par, we, prot, chan, rej, aux, exp[4:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h01}, // R1
    {1'b0,1'b1,16'h0003,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h02}, // R2 even
    {1'b0,1'b1,16'h0003,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'h00}, // R2 odd
    {1'b0,1'b1,16'h0001,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h00}, // R2 odd
    {1'b0,1'b1,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h02}, // R2 zero ones
    {1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h00}, // R2 no transfer
    {1'b0,1'b0,16'h0000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,5'h04}, // R3
    {1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,5'h00}, // R3 unprotected
    {1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'h08}, // R4 check
    {1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,5'h08}, // R4 reject
    {1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'h00}, // R5 alone
    {1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'h11}, // R5 with op
    {1'b0,1'b1,16'hFFFF,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,5'h16}  // R5 multi
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bad_opcode_i, xfer_valid_i, xfer_par_i, wr_en_i, wr_protect_i;
  logic chan_check_i, cmd_reject_i, aux_access_i, sense_i;
  logic [15:0] xfer_data_i;
  logic [15:0] word_o;
  logic irq_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_err_status dut_i (
    .clk(clk), .rst_n(rst_n), .bad_opcode_i(bad_opcode_i),
    .xfer_valid_i(xfer_valid_i), .xfer_data_i(xfer_data_i),
    .xfer_par_i(xfer_par_i), .wr_en_i(wr_en_i), .wr_protect_i(wr_protect_i),
    .chan_check_i(chan_check_i), .cmd_reject_i(cmd_reject_i),
    .aux_access_i(aux_access_i), .sense_i(sense_i),
    .word_o(word_o), .irq_o(irq_o)
  );

  task automatic idle();
    {bad_opcode_i, xfer_valid_i, xfer_par_i, wr_en_i, wr_protect_i} = '0;
    {chan_check_i, cmd_reject_i, aux_access_i, sense_i} = '0;
    xfer_data_i = '0;
  endtask

  task automatic check(input string req, input logic [15:0] exp);
    logic exp_irq;
    exp_irq = |exp[3:0];
    checks++;
    if (word_o !== exp || irq_o !== exp_irq) begin
      fails++;
      $display("FAIL %s word=%h irq=%b expected word=%h irq=%b",
               req, word_o, irq_o, exp, exp_irq);
    end
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_sense();
    sense_i = 1'b1;
    step();
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset", 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      {bad_opcode_i, xfer_valid_i, xfer_data_i, xfer_par_i, wr_en_i,
       wr_protect_i, chan_check_i, cmd_reject_i, aux_access_i} = VEC[i][28:5];
      step();
      check($sformatf("R1/R2/R3/R4/R5/R9/R10 vector %0d", i), {11'h0, VEC[i][4:0]});
      do_sense();
      check($sformatf("R7 clear after vector %0d", i), 16'h0000);
    end

    // R6: bits persist and accumulate
    bad_opcode_i = 1'b1;
    step();
    repeat (3) @(negedge clk);
    check("R6 hold", 16'h0001);
    chan_check_i = 1'b1;
    step();
    check("R6 accumulate", 16'h0009);
    // R8: event coinciding with sense survives, old bits cleared
    sense_i = 1'b1;
    wr_en_i = 1'b1;
    wr_protect_i = 1'b1;
    step();
    check("R8 event during sense", 16'h0004);
    do_sense();
    check("R7 clear", 16'h0000);
    // R5 aux alone leaves the word and request idle
    aux_access_i = 1'b1;
    step();
    check("R5 aux alone", 16'h0000);
    // R11 asynchronous reset with bits set
    cmd_reject_i = 1'b1;
    aux_access_i = 1'b1;
    step();
    check("R5 reject with aux", 16'h0018);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset clears", 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule